// File: doc/BRIEF.md
# Instruction Operand Fetch Sequencer

This block takes one 16-bit instruction word and turns its two operand fields into operand descriptors that an execute stage can consume directly. The word carries an opcode, a 6-bit source field (a) and a 5-bit destination field (b). Both fields draw on one shared code space. A code can name a general register, a memory location addressed by a register, a memory location at register plus an inline word, a stack slot, SP, PC, EX, or a literal. Some codes pull an extra instruction word from memory. Each such word costs one registered read cycle and advances PC. The stack-slot code pops when it sits in a and pushes when it sits in b.

A caller pulses `start_i` with the instruction word, the PC of the word that follows it, SP, the eight register values and EX. The register values and EX must stay steady while `busy_o` is high. The sequencer resolves a first and b second. It drives a single read port whose data returns one cycle after the request. When both operands are resolved it pulses `done_o`. The descriptors, opcode, final PC and final SP then hold until the next accepted start.

Each descriptor carries a kind: register (code 0), memory (code 1) or literal (code 2). A write-back stage uses the kind to decide where a result goes. It discards any write to a literal.

Top module: `operand_fetch_seq`

## Requirements
- R1: The fields of the word are opcode = bits 4:0, b = bits 9:5 and a = bits 15:10. `opcode_o` shows bits 4:0 of the accepted word.
- R2: Codes 0x00-0x07 give kind 0 (register), value = register A,B,C,X,Y,Z,I,J in that order, and addr = the register index 0-7.
- R3: Codes 0x08-0x0f give kind 1 (memory), addr = the value of the register selected by code bits 2:0, and value 0.
- R4: Codes 0x10-0x17 give kind 1 with addr = register + next word (modulo 2^16). Reading the next word reads memory at PC, then increments PC, and costs one cycle.
- R5: Code 0x18 in a gives kind 1, addr = SP, and then SP increments. In b, SP decrements first and addr = the new SP. SP wraps modulo 2^16.
- R6: Code 0x19 gives kind 1 with addr = SP. Code 0x1a gives kind 1 with addr = SP + next word.
- R7: Codes 0x1b, 0x1c and 0x1d give kind 0 with value SP, PC or EX and addr 8, 9 or 10. The SP and PC values are the ones current when that operand is resolved.
- R8: Code 0x1e gives kind 1 with addr = next word. Code 0x1f gives kind 2 (literal) with value = next word and addr 0.
- R9: Codes 0x20-0x3f exist only in a and give kind 2 with value = code - 0x21 modulo 2^16 (0xffff up to 0x001e) and addr 0.
- R10: a is resolved before b. a's next word sits at the lower address. b sees PC and SP after a's effects. `pc_o` and `sp_o` give the final values.
- R11: `done_o` is a single-cycle pulse. It rises 2+N rising edges after the edge that accepts `start_i`, where N is the number of extra words read. Read data is taken one cycle after `mem_rd_o`.
- R12: A `start_i` that arrives while `busy_o` is high is ignored.
- R13: While idle and without a start, the descriptors, opcode, `pc_o` and `sp_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept `instr_i`, `pc_i` and `sp_i` when idle |
| instr_i | input | 16 | Instruction word |
| regs_i | input | 8*DATA_W | Registers A..J, A in the lowest slice |
| ex_i | input | DATA_W | EX register value |
| pc_i | input | DATA_W | Address of the word after the instruction |
| sp_i | input | DATA_W | Stack pointer at start |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | DATA_W | Read address (current PC) |
| mem_data_i | input | DATA_W | Read data, one cycle after the request |
| busy_o | output | 1 | Resolution in progress |
| done_o | output | 1 | One-cycle completion pulse |
| opcode_o | output | 5 | Opcode field |
| a_kind_o | output | 2 | Kind of a: 0 reg, 1 mem, 2 literal |
| a_val_o | output | DATA_W | Value of a (register or literal) |
| a_addr_o | output | DATA_W | Register selector or effective address of a |
| b_kind_o | output | 2 | Kind of b |
| b_val_o | output | DATA_W | Value of b |
| b_addr_o | output | DATA_W | Register selector or effective address of b |
| pc_o | output | DATA_W | PC after all consumed words |
| sp_o | output | DATA_W | SP after push/pop |

## Verification
The bench builds the block with DATA_W = 16, which is the width the literal range and the wrap cases assume. At that width all 64 × 32 pairs of a and b codes can be applied, so every ordering of pop, push, extra-word reads and SP/PC reads in one word is covered. Across the sweep, SP starts at 0x0000 on some runs and PC at 0xffff on others. This makes push underflow and next-word fetch wrap happen inside the sweep.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int NREG    = 8;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 5;
  localparam int SEL_SP  = 8;
  localparam int SEL_PC  = 9;
  localparam int SEL_EX  = 10;

  typedef enum logic [1:0] {
    KIND_REG = 2'd0,
    KIND_MEM = 2'd1,
    KIND_LIT = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_A, ST_AW, ST_B, ST_BW
  } state_e;
endpackage

// File: rtl/ofs_reg_pick.sv
module ofs_reg_pick #(
  parameter int DATA_W = 16,
  parameter int NUM    = 8,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic [NUM*DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [DATA_W-1:0]     val_o
);
  logic [DATA_W-1:0] arr [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_unpack
    assign arr[i] = regs_i[i*DATA_W +: DATA_W];
  end

  assign val_o = arr[sel_i];
endmodule

// File: rtl/ofs_operand_resolve.sv
module ofs_operand_resolve
  import ofs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [5:0]             code_i,
  input  logic                   is_a_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]      sp_i,
  input  logic [DATA_W-1:0]      pc_i,
  input  logic [DATA_W-1:0]      ex_i,
  input  logic [DATA_W-1:0]      nw_i,
  output logic                   need_nw_o,
  output kind_e                  kind_o,
  output logic [DATA_W-1:0]      val_o,
  output logic [DATA_W-1:0]      addr_o,
  output logic [DATA_W-1:0]      sp_nxt_o
);
  logic [DATA_W-1:0] reg_val;

  ofs_reg_pick #(.DATA_W(DATA_W), .NUM(NREG)) u_pick (
    .regs_i (regs_i),
    .sel_i  (code_i[2:0]),
    .val_o  (reg_val)
  );

  always_comb begin
    need_nw_o = 1'b0;
    kind_o    = KIND_REG;
    val_o     = '0;
    addr_o    = '0;
    sp_nxt_o  = sp_i;
    if (code_i[5]) begin
      // inline literal, -1..30
      kind_o = KIND_LIT;
      val_o  = DATA_W'(code_i[4:0]) - DATA_W'(1);
    end else begin
      unique case (code_i[4:3])
        2'd0: begin
          val_o  = reg_val;
          addr_o = DATA_W'(code_i[2:0]);
        end
        2'd1: begin
          kind_o = KIND_MEM;
          addr_o = reg_val;
        end
        2'd2: begin
          kind_o    = KIND_MEM;
          addr_o    = reg_val + nw_i;
          need_nw_o = 1'b1;
        end
        default: begin
          unique case (code_i[2:0])
            3'd0: begin
              kind_o = KIND_MEM;
              if (is_a_i) begin
                addr_o   = sp_i;
                sp_nxt_o = sp_i + DATA_W'(1);
              end else begin
                addr_o   = sp_i - DATA_W'(1);
                sp_nxt_o = sp_i - DATA_W'(1);
              end
            end
            3'd1: begin
              kind_o = KIND_MEM;
              addr_o = sp_i;
            end
            3'd2: begin
              kind_o    = KIND_MEM;
              addr_o    = sp_i + nw_i;
              need_nw_o = 1'b1;
            end
            3'd3: begin
              val_o  = sp_i;
              addr_o = DATA_W'(SEL_SP);
            end
            3'd4: begin
              val_o  = pc_i;
              addr_o = DATA_W'(SEL_PC);
            end
            3'd5: begin
              val_o  = ex_i;
              addr_o = DATA_W'(SEL_EX);
            end
            3'd6: begin
              kind_o    = KIND_MEM;
              addr_o    = nw_i;
              need_nw_o = 1'b1;
            end
            default: begin
              kind_o    = KIND_LIT;
              val_o     = nw_i;
              need_nw_o = 1'b1;
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_fetch_seq.sv
module operand_fetch_seq
  import ofs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [INSTR_W-1:0]     instr_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]      ex_i,
  input  logic [DATA_W-1:0]      pc_i,
  input  logic [DATA_W-1:0]      sp_i,
  output logic                   mem_rd_o,
  output logic [DATA_W-1:0]      mem_addr_o,
  input  logic [DATA_W-1:0]      mem_data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [OPC_W-1:0]       opcode_o,
  output logic [1:0]             a_kind_o,
  output logic [DATA_W-1:0]      a_val_o,
  output logic [DATA_W-1:0]      a_addr_o,
  output logic [1:0]             b_kind_o,
  output logic [DATA_W-1:0]      b_val_o,
  output logic [DATA_W-1:0]      b_addr_o,
  output logic [DATA_W-1:0]      pc_o,
  output logic [DATA_W-1:0]      sp_o
);
  state_e             st;
  logic [INSTR_W-1:0] instr_q;
  logic [DATA_W-1:0]  pc_q, sp_q;
  logic               done_q;
  kind_e              a_kind_q, b_kind_q;
  logic [DATA_W-1:0]  a_val_q, a_addr_q, b_val_q, b_addr_q;

  logic              in_a, issue_st;
  logic [5:0]        code;
  logic              need_nw;
  kind_e             r_kind;
  logic [DATA_W-1:0] r_val, r_addr, r_sp_nxt;

  assign in_a     = (st == ST_A) || (st == ST_AW);
  assign issue_st = (st == ST_A) || (st == ST_B);
  assign code     = in_a ? instr_q[15:10] : {1'b0, instr_q[9:5]};

  ofs_operand_resolve #(.DATA_W(DATA_W)) u_res (
    .code_i    (code),
    .is_a_i    (in_a),
    .regs_i    (regs_i),
    .sp_i      (sp_q),
    .pc_i      (pc_q),
    .ex_i      (ex_i),
    .nw_i      (mem_data_i),
    .need_nw_o (need_nw),
    .kind_o    (r_kind),
    .val_o     (r_val),
    .addr_o    (r_addr),
    .sp_nxt_o  (r_sp_nxt)
  );

  assign mem_rd_o   = issue_st && need_nw;
  assign mem_addr_o = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      instr_q  <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      done_q   <= 1'b0;
      a_kind_q <= KIND_REG;
      b_kind_q <= KIND_REG;
      a_val_q  <= '0;
      a_addr_q <= '0;
      b_val_q  <= '0;
      b_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          instr_q <= instr_i;
          pc_q    <= pc_i;
          sp_q    <= sp_i;
          st      <= ST_A;
        end
        ST_A, ST_AW: begin
          if (st == ST_A && need_nw) begin
            pc_q <= pc_q + DATA_W'(1);
            st   <= ST_AW;
          end else begin
            a_kind_q <= r_kind;
            a_val_q  <= r_val;
            a_addr_q <= r_addr;
            sp_q     <= r_sp_nxt;
            st       <= ST_B;
          end
        end
        default: begin
          if (st == ST_B && need_nw) begin
            pc_q <= pc_q + DATA_W'(1);
            st   <= ST_BW;
          end else begin
            b_kind_q <= r_kind;
            b_val_q  <= r_val;
            b_addr_q <= r_addr;
            sp_q     <= r_sp_nxt;
            done_q   <= 1'b1;
            st       <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o   = (st != ST_IDLE);
  assign done_o   = done_q;
  assign opcode_o = instr_q[OPC_W-1:0];
  assign a_kind_o = a_kind_q;
  assign a_val_o  = a_val_q;
  assign a_addr_o = a_addr_q;
  assign b_kind_o = b_kind_q;
  assign b_val_o  = b_val_q;
  assign b_addr_o = b_addr_q;
  assign pc_o     = pc_q;
  assign sp_o     = sp_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  nw_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (pc_o == $past(pc_o) + DATA_W'(1)));

  // R12
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(opcode_o));

  // R13
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pc_o) && $stable(sp_o) &&
                               $stable(a_val_o) && $stable(b_val_o)));

  // R5
  sp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (sp_o == $past(sp_o) || sp_o == $past(sp_o) + DATA_W'(1) ||
                sp_o == $past(sp_o) - DATA_W'(1)));

  // R9
  lit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && a_kind_o == 2'd2) |-> (instr_q[15] || instr_q[15:10] == 6'h1f));

  // R11
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);
endmodule

// File: tb/sim_operand_fetch_seq.sv
module sim_operand_fetch_seq;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   instr = '0;
  logic [8*DW-1:0] regs_flat = '0;
  logic [DW-1:0] ex_v = '0, pc_in = '0, sp_in = '0;
  logic          mem_rd;
  logic [DW-1:0] mem_addr, mem_q = '0;
  logic          busy, done;
  logic [4:0]    opcode;
  logic [1:0]    a_kind, b_kind;
  logic [DW-1:0] a_val, a_addr, b_val, b_addr, pc_out, sp_out;
  logic [DW-1:0] reg_v [8];

  int vectors = 0;
  int fails   = 0;

  always #2.5 clk = ~clk;

  operand_fetch_seq #(.DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .regs_i(regs_flat), .ex_i(ex_v), .pc_i(pc_in), .sp_i(sp_in),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
    .busy_o(busy), .done_o(done), .opcode_o(opcode),
    .a_kind_o(a_kind), .a_val_o(a_val), .a_addr_o(a_addr),
    .b_kind_o(b_kind), .b_val_o(b_val), .b_addr_o(b_addr),
    .pc_o(pc_out), .sp_o(sp_out)
  );

  function automatic logic [15:0] memf(logic [15:0] ad);
    return (ad * 16'h9e37) ^ 16'h3c5a;
  endfunction

  always @(posedge clk) if (mem_rd) mem_q <= memf(mem_addr);

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [5:0] c);
    if (c >= 6'h20) return "R9";
    if (c < 6'h08)  return "R2";
    if (c < 6'h10)  return "R3";
    if (c < 6'h18)  return "R4";
    if (c == 6'h18) return "R5";
    if (c < 6'h1b)  return "R6";
    if (c < 6'h1e)  return "R7";
    return "R8";
  endfunction

  task automatic ref_op(input logic [5:0] c, input bit is_a,
                        inout logic [15:0] pc, inout logic [15:0] sp, inout int nwc,
                        output logic [1:0] k, output logic [15:0] v, output logic [15:0] ad);
    logic [15:0] nw, r;
    r = reg_v[c[2:0]]; nw = '0; k = 2'd0; v = '0; ad = '0;
    if ((c >= 6'h10 && c <= 6'h17) || c == 6'h1a || c == 6'h1e || c == 6'h1f) begin
      nw = memf(pc); pc = pc + 16'd1; nwc++;
    end
    if (c >= 6'h20) begin k = 2'd2; v = 16'(int'(c) - 33); end
    else if (c < 6'h08) begin v = r; ad = 16'(c); end
    else if (c < 6'h10) begin k = 2'd1; ad = r; end
    else if (c < 6'h18) begin k = 2'd1; ad = r + nw; end
    else case (c)
      6'h18: begin
        k = 2'd1;
        if (is_a) begin ad = sp; sp = sp + 16'd1; end
        else begin sp = sp - 16'd1; ad = sp; end
      end
      6'h19: begin k = 2'd1; ad = sp; end
      6'h1a: begin k = 2'd1; ad = sp + nw; end
      6'h1b: begin v = sp; ad = 16'd8; end
      6'h1c: begin v = pc; ad = 16'd9; end
      6'h1d: begin v = ex_v; ad = 16'd10; end
      6'h1e: begin k = 2'd1; ad = nw; end
      default: begin k = 2'd2; v = nw; end
    endcase
  endtask

  task automatic load_regs(int k);
    for (int i = 0; i < 8; i++) begin
      reg_v[i] = 16'(k * 7 + i * 16'h2111);
      regs_flat[i*16 +: 16] = reg_v[i];
    end
    ex_v = 16'(~k);
  endtask

  task automatic run(logic [15:0] w, output int cnt);
    @(negedge clk);
    instr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt = 1;
    while (!done && cnt < 20) begin
      @(negedge clk); cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [15:0] w, pc_e, sp_e;
    logic [1:0] ka, kb;
    logic [15:0] va, aa, vb, ab;
    int nwc;

    repeat (3) @(negedge clk);
    // reset state
    chk("R11 reset busy/done/rd", {45'd0, busy, done, mem_rd}, 48'd0);
    chk("R10 reset pc/sp", {16'd0, pc_out, sp_out}, 48'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive a x b sweep
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 32; b++) begin
        int k = a * 32 + b;
        load_regs(k);
        pc_in = k[0] ? 16'hffff : 16'(16'h0400 + k);
        sp_in = k[1] ? 16'h0000 : 16'(16'hc000 + k);
        w = {6'(a), 5'(b), 5'(k % 32)};
        pc_e = pc_in; sp_e = sp_in; nwc = 0;
        ref_op(6'(a), 1'b1, pc_e, sp_e, nwc, ka, va, aa);
        ref_op({1'b0, 5'(b)}, 1'b0, pc_e, sp_e, nwc, kb, vb, ab);
        run(w, cnt);
        chk("R11 done latency", 48'(cnt), 48'(3 + nwc));
        chk("R1 opcode", 48'(opcode), 48'(w[4:0]));
        chk({tag_of(6'(a)), " a operand"}, {14'd0, a_kind, a_val, a_addr}, {14'd0, ka, va, aa});
        chk({tag_of({1'b0, 5'(b)}), " b operand"}, {14'd0, b_kind, b_val, b_addr}, {14'd0, kb, vb, ab});
        chk("R10 final pc/sp", {16'd0, pc_out, sp_out}, {16'd0, pc_e, sp_e});
      end
    end

    // R12: start held during busy is ignored
    load_regs(5);
    pc_in = 16'h1230; sp_in = 16'h4000;
    @(negedge clk);
    instr = {6'h1e, 5'h10, 5'h03}; start = 1'b1;
    @(negedge clk);
    instr = 16'h0000; pc_in = 16'h9999; sp_in = 16'h7777;
    @(negedge clk);
    start = 1'b0; cnt = 2;
    while (!done && cnt < 20) begin @(negedge clk); cnt++; end
    chk("R12 opcode kept", 48'(opcode), 48'd3);
    chk("R12 a kept", {14'd0, a_kind, a_val, a_addr}, {14'd0, 2'd1, 16'd0, memf(16'h1230)});
    chk("R12 b kept", {14'd0, b_kind, b_val, b_addr},
        {14'd0, 2'd1, 16'd0, 16'(reg_v[0] + memf(16'h1231))});
    chk("R12 pc/sp kept", {16'd0, pc_out, sp_out}, {16'd0, 16'h1232, 16'h4000});

    // R13: idle hold while inputs move
    load_regs(77);
    for (int i = 0; i < 6; i++) begin
      pc_in = 16'(i * 3); sp_in = 16'(i * 5); ex_v = 16'(i);
      @(negedge clk);
    end
    chk("R13 hold pc/sp", {16'd0, pc_out, sp_out}, {16'd0, 16'h1232, 16'h4000});
    chk("R13 hold a", {14'd0, a_kind, a_val, a_addr}, {14'd0, 2'd1, 16'd0, memf(16'h1230)});
    chk("R13 no done/busy", {46'd0, busy, done}, 48'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule